// File: doc/BRIEF.md
# Update-Protocol Coherence Line Controller

This block keeps the coherence state of one cache line under a write-back snooping protocol in which writes to shared data are pushed to the other caches as a single-word broadcast, rather than invalidating their copies. A present line is always in one of four valid states: exclusive-clean, shared-clean, shared-modified (the owner of dirty shared data) and dirty. A line that is absent is held in a separate "none" code, which is not a protocol state. Memory is not written when a word is broadcast, so exactly one cache keeps ownership of modified shared data.

The processor side offers read, write and evict requests. The controller works out from its own state whether a read or a write is a hit or a miss. It then either completes the request at once, or requests the bus and issues a read, a word update or a write-back when granted. It samples the wired-OR shared line in the granted cycle. On the snoop side it watches transactions from other caches. It drives its contribution to the shared line, a flush strobe when it must supply the line, and an apply strobe with the word when another cache broadcasts an update.

Top module: `upd_coh_line`

## Requirements
- R1: After reset, line_state is 0 (none), bus_req and cpu_done are low and cpu_ready is high. State codes: 0 none, 1 exclusive-clean, 2 shared-clean, 3 shared-modified, 4 dirty.
- R2: A read when the line is absent requests the bus with bus_cmd 1 (read). When granted, the line fills to shared-clean if bus_shared is high and to exclusive-clean otherwise, and cpu_done pulses one cycle later.
- R3: A write when the line is absent first issues a read. If bus_shared is low at that grant, the line goes straight to dirty with no update. Otherwise it holds shared-clean and issues bus_cmd 2 (update) on the next grant.
- R4: A write hit in exclusive-clean goes to dirty with no bus request. A write hit in shared-clean or shared-modified issues an update carrying the written word on bus_word, and ends in shared-modified if bus_shared is high at the grant and in dirty otherwise. A write hit in dirty completes with no bus request.
- R5: A snooped update (snp_cmd 2) on a present line raises shared_out and upd_apply with upd_word equal to snp_word. A line in shared-modified drops to shared-clean.
- R6: A snooped read (snp_cmd 1) on a present line raises shared_out. Dirty or shared-modified lines raise flush_out and end in shared-modified. Exclusive-clean goes to shared-clean.
- R7: Evicting a dirty or shared-modified line issues bus_cmd 3 (write-back) and ends in none. Evicting a clean line completes in one cycle with no bus request.
- R8: While snp_valid is high, cpu_ready is low and a processor request presented in that cycle is not accepted.
- R9: cpu_op 3 is ignored: no state change, no bus request and no completion pulse.
- R10: Snoops on an absent line raise none of shared_out, flush_out or upd_apply.
- R11: Whether an eviction writes back is decided from the state at the grant. If a snoop demoted the line to a clean state while the request was pending, the granted cycle carries bus_cmd 0 and the line still ends in none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 ignored |
| cpu_wdata | input | WORD_W | Word written by a write request |
| cpu_ready | output | 1 | Request accepted on this edge if valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus wanted for a pending transaction |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 update, 3 write-back |
| bus_word | output | WORD_W | Word carried by an update |
| bus_shared | input | 1 | Wired-OR shared line, sampled at grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_word | input | WORD_W | Word of a snooped update |
| shared_out | output | 1 | This cache holds the snooped line |
| flush_out | output | 1 | This cache must supply the line |
| upd_apply | output | 1 | Write upd_word into the local copy |
| upd_word | output | WORD_W | Word to apply |
| line_state | output | 3 | Current state code |

## Verification
The hardest situation to reach is an eviction whose write-back decision changes while it waits for the bus. The stimulus builds a shared-modified line through a shared read miss and a shared write. It then starts an eviction, withholds the grant, and drives a snooped update that demotes the line. Only then is the grant given, so the bench can see an empty granted slot. A second timing corner, a processor request in the same cycle as a snoop, is produced by raising both inputs on one edge.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        LS_NONE  = 3'd0,
        LS_EXCL  = 3'd1,
        LS_SHC   = 3'd2,
        LS_SHM   = 3'd3,
        LS_DIRTY = 3'd4
    } lstate_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } cpu_op_t;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_READ = 2'd1,
        BC_UPD  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RD   = 2'd1,
        SQ_UPD  = 2'd2,
        SQ_WB   = 2'd3
    } seq_t;

    typedef struct packed {
        logic    we;
        lstate_t nxt;
    } st_wr_t;

    function automatic logic is_present(lstate_t s);
        return s != LS_NONE;
    endfunction

    function automatic logic is_owner(lstate_t s);
        return (s == LS_DIRTY) || (s == LS_SHM);
    endfunction

    function automatic lstate_t fill_state(logic shared);
        return shared ? LS_SHC : LS_EXCL;
    endfunction

    function automatic lstate_t after_update(logic shared);
        return shared ? LS_SHM : LS_DIRTY;
    endfunction

    function automatic lstate_t snoop_next(lstate_t s, bus_cmd_t c);
        lstate_t r;
        r = s;
        if (c == BC_READ) begin
            case (s)
                LS_EXCL:  r = LS_SHC;
                LS_DIRTY: r = LS_SHM;
                default:  r = s;
            endcase
        end else if (c == BC_UPD) begin
            if (s == LS_SHM) r = LS_SHC;
        end
        return r;
    endfunction

endpackage

// File: rtl/coh_snoop.sv
module coh_snoop
    import coh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lstate_t  state,
    input  logic     snp_valid,
    input  bus_cmd_t snp_cmd,
    output st_wr_t   wr,
    output logic     shared_out,
    output logic     flush_out,
    output logic     apply
);
    logic hit;
    logic is_rd;
    logic is_upd;

    always_comb begin
        hit        = snp_valid && is_present(state);
        is_rd      = snp_cmd == BC_READ;
        is_upd     = snp_cmd == BC_UPD;
        shared_out = hit && (is_rd || is_upd);
        flush_out  = hit && is_rd && is_owner(state);
        apply      = hit && is_upd;
        wr.we      = hit && (is_rd || is_upd);
        wr.nxt     = snoop_next(state, snp_cmd);
    end

    // R6: only an owner supplies data
    a_r6_flush_owner: assert property (@(posedge clk) disable iff (rst)
        flush_out |-> (state == LS_DIRTY || state == LS_SHM));

    // R10: absent line stays silent on the bus
    a_r10_absent_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == LS_NONE) |-> !(shared_out || flush_out || apply));

endmodule

// File: rtl/coh_seq.sv
module coh_seq
    import coh_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  lstate_t           state,
    input  logic              cpu_valid,
    input  cpu_op_t           cpu_op,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              snp_valid,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    output st_wr_t            wr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req,
    output bus_cmd_t          bus_cmd,
    output logic [WORD_W-1:0] bus_word
);
    seq_t              fsm, fsm_n;
    logic              pend_wr, pend_wr_n;
    logic              done_n;
    logic [WORD_W-1:0] word_q, word_n;
    logic              accept;

    always_comb begin
        cpu_ready = (fsm == SQ_IDLE) && !snp_valid;
        accept    = cpu_valid && cpu_ready;
        bus_req   = fsm != SQ_IDLE;
        bus_word  = word_q;
        case (fsm)
            SQ_RD:   bus_cmd = BC_READ;
            SQ_UPD:  bus_cmd = BC_UPD;
            SQ_WB:   bus_cmd = is_owner(state) ? BC_WB : BC_NONE;
            default: bus_cmd = BC_NONE;
        endcase
    end

    always_comb begin
        fsm_n     = fsm;
        pend_wr_n = pend_wr;
        done_n    = 1'b0;
        word_n    = word_q;
        wr.we     = 1'b0;
        wr.nxt    = state;
        case (fsm)
            SQ_IDLE: if (accept) begin
                case (cpu_op)
                    OP_READ: begin
                        if (is_present(state)) done_n = 1'b1;
                        else begin
                            fsm_n     = SQ_RD;
                            pend_wr_n = 1'b0;
                        end
                    end
                    OP_WRITE: begin
                        word_n = cpu_wdata;
                        case (state)
                            LS_NONE: begin
                                fsm_n     = SQ_RD;
                                pend_wr_n = 1'b1;
                            end
                            LS_EXCL: begin
                                wr.we  = 1'b1;
                                wr.nxt = LS_DIRTY;
                                done_n = 1'b1;
                            end
                            LS_DIRTY: done_n = 1'b1;
                            default:  fsm_n = SQ_UPD;
                        endcase
                    end
                    OP_EVICT: begin
                        if (is_owner(state)) fsm_n = SQ_WB;
                        else begin
                            wr.we  = is_present(state);
                            wr.nxt = LS_NONE;
                            done_n = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            SQ_RD: if (bus_gnt) begin
                wr.we = 1'b1;
                if (!pend_wr) begin
                    wr.nxt = fill_state(bus_shared);
                    done_n = 1'b1;
                    fsm_n  = SQ_IDLE;
                end else if (bus_shared) begin
                    wr.nxt = LS_SHC;
                    fsm_n  = SQ_UPD;
                end else begin
                    wr.nxt = LS_DIRTY;
                    done_n = 1'b1;
                    fsm_n  = SQ_IDLE;
                end
            end
            SQ_UPD: if (bus_gnt) begin
                wr.we  = 1'b1;
                wr.nxt = after_update(bus_shared);
                done_n = 1'b1;
                fsm_n  = SQ_IDLE;
            end
            SQ_WB: if (bus_gnt) begin
                wr.we  = 1'b1;
                wr.nxt = LS_NONE;
                done_n = 1'b1;
                fsm_n  = SQ_IDLE;
            end
            default: fsm_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm      <= SQ_IDLE;
            pend_wr  <= 1'b0;
            cpu_done <= 1'b0;
            word_q   <= '0;
        end else begin
            fsm      <= fsm_n;
            pend_wr  <= pend_wr_n;
            cpu_done <= done_n;
            word_q   <= word_n;
        end
    end

    // R4: a write hit on an exclusive-clean line never touches the bus
    a_r4_excl_write_silent: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_op == OP_WRITE && state == LS_EXCL) |=> !bus_req);

    // R4 / R3: a word update is only broadcast from a shared state
    a_r4_upd_from_shared: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd == BC_UPD) |-> (state == LS_SHC || state == LS_SHM));

    // R7: a write-back comes only from an owner
    a_r7_wb_owner: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == BC_WB) |-> is_owner(state));

    // R8: no acceptance while a snoop is on the bus
    a_r8_snoop_blocks: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !cpu_ready);

endmodule

// File: rtl/upd_coh_line.sv
module upd_coh_line
    import coh_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [WORD_W-1:0] bus_word,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [WORD_W-1:0] snp_word,
    output logic              shared_out,
    output logic              flush_out,
    output logic              upd_apply,
    output logic [WORD_W-1:0] upd_word,
    output logic [2:0]        line_state
);
    lstate_t  st_q;
    st_wr_t   seq_wr;
    st_wr_t   snp_wr;
    bus_cmd_t cmd_i;

    coh_seq #(.WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .state      (st_q),
        .cpu_valid  (cpu_valid),
        .cpu_op     (cpu_op_t'(cpu_op)),
        .cpu_wdata  (cpu_wdata),
        .snp_valid  (snp_valid),
        .bus_gnt    (bus_gnt),
        .bus_shared (bus_shared),
        .wr         (seq_wr),
        .cpu_ready  (cpu_ready),
        .cpu_done   (cpu_done),
        .bus_req    (bus_req),
        .bus_cmd    (cmd_i),
        .bus_word   (bus_word)
    );

    coh_snoop u_snoop (
        .clk        (clk),
        .rst        (rst),
        .state      (st_q),
        .snp_valid  (snp_valid),
        .snp_cmd    (bus_cmd_t'(snp_cmd)),
        .wr         (snp_wr),
        .shared_out (shared_out),
        .flush_out  (flush_out),
        .apply      (upd_apply)
    );

    always_ff @(posedge clk) begin
        if (rst)            st_q <= LS_NONE;
        else if (snp_wr.we) st_q <= snp_wr.nxt;
        else if (seq_wr.we) st_q <= seq_wr.nxt;
    end

    always_comb begin
        bus_cmd    = cmd_i;
        upd_word   = snp_word;
        line_state = st_q;
    end

    // R5: a snooped update takes ownership away
    a_r5_upd_demotes: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == 2'd2 && st_q == LS_SHM) |=> (line_state == 3'd2));

    // R6: a snooped read leaves an owner in shared-modified
    a_r6_owner_keeps: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == 2'd1 && is_owner(st_q)) |=> (line_state == 3'd3));

    // R1: the state code is always a legal one
    a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
        line_state <= 3'd4);

endmodule

// File: tb/tb_upd_coh_line.sv
module tb_upd_coh_line;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         cpu_valid, bus_gnt, bus_shared, snp_valid;
    logic [1:0]   cpu_op, snp_cmd;
    logic [W-1:0] cpu_wdata, snp_word;
    logic         cpu_ready, cpu_done, bus_req, shared_out, flush_out, upd_apply;
    logic [1:0]   bus_cmd;
    logic [W-1:0] bus_word, upd_word;
    logic [2:0]   line_state;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    always #4 clk = ~clk;

    upd_coh_line #(.WORD_W(W)) dut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
        .bus_word(bus_word), .bus_shared(bus_shared), .snp_valid(snp_valid),
        .snp_cmd(snp_cmd), .snp_word(snp_word), .shared_out(shared_out),
        .flush_out(flush_out), .upd_apply(upd_apply), .upd_word(upd_word),
        .line_state(line_state)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic cpu_issue(logic [1:0] op, logic [W-1:0] word);
        cpu_valid = 1; cpu_op = op; cpu_wdata = word;
        @(negedge clk);
        cpu_valid = 0;
    endtask

    task automatic grant(logic sh, logic [1:0] exp_cmd, string tag);
        chk({tag, " bus_req"}, bus_req, 1);
        chk({tag, " bus_cmd"}, bus_cmd, exp_cmd);
        bus_gnt = 1; bus_shared = sh;
        @(negedge clk);
        bus_gnt = 0; bus_shared = 0;
    endtask

    task automatic snoop(logic [1:0] c, logic [W-1:0] w, bit e_sh, bit e_fl, bit e_ap, string tag);
        snp_valid = 1; snp_cmd = c; snp_word = w;
        #1;
        chk({tag, " shared_out"}, shared_out, e_sh);
        chk({tag, " flush_out"}, flush_out, e_fl);
        chk({tag, " upd_apply"}, upd_apply, e_ap);
        if (e_ap) chk({tag, " upd_word"}, upd_word, w);
        @(negedge clk);
        snp_valid = 0;
    endtask

    task automatic evict_clean(string tag);
        cpu_issue(2'd2, '0);
        chk({tag, " done"}, cpu_done, 1);
        chk({tag, " no bus"}, bus_req, 0);
        chk({tag, " none"}, line_state, 0);
    endtask

    task automatic evict_owner(string tag);
        cpu_issue(2'd2, '0);
        grant(1'b0, 2'd3, tag);
        chk({tag, " none"}, line_state, 0);
        chk({tag, " done"}, cpu_done, 1);
    endtask

    task automatic t_reset();
        chk("R1 state", line_state, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 done", cpu_done, 0);
        chk("R1 ready", cpu_ready, 1);
    endtask

    task automatic t_read_miss();
        cpu_issue(2'd0, '0);
        grant(1'b0, 2'd1, "R2 excl");
        chk("R2 fill excl", line_state, 1);
        chk("R2 done", cpu_done, 1);
        snoop(2'd1, '0, 1, 0, 0, "R6 rd on E");
        chk("R6 E to Sc", line_state, 2);
        evict_clean("R7 Sc silent");
        cpu_issue(2'd0, '0);
        grant(1'b1, 2'd1, "R2 shared");
        chk("R2 fill Sc", line_state, 2);
        evict_clean("R7 Sc silent 2");
    endtask

    task automatic t_write_hit_update();
        cpu_issue(2'd0, '0);
        grant(1'b1, 2'd1, "R2 fill");
        cpu_issue(2'd1, 32'hA5A5_0001);
        chk("R4 bus_word", bus_word, 32'hA5A5_0001);
        grant(1'b1, 2'd2, "R4 upd Sc");
        chk("R4 Sc->Sm", line_state, 3);
        chk("R4 done", cpu_done, 1);
        snoop(2'd1, '0, 1, 1, 0, "R6 rd on Sm");
        chk("R6 Sm stays", line_state, 3);
        snoop(2'd2, 32'h0000_0077, 1, 0, 1, "R5 upd on Sm");
        chk("R5 Sm->Sc", line_state, 2);
        cpu_issue(2'd1, 32'h0000_0042);
        chk("R4 bus_word 2", bus_word, 32'h0000_0042);
        grant(1'b0, 2'd2, "R4 upd unshared");
        chk("R4 Sc->D", line_state, 4);
        cpu_issue(2'd1, 32'h1);
        chk("R4 D hit done", cpu_done, 1);
        chk("R4 D hit no bus", bus_req, 0);
        evict_owner("R7 wb D");
    endtask

    task automatic t_write_miss();
        cpu_issue(2'd1, 32'h11);
        grant(1'b0, 2'd1, "R3 rd unshared");
        chk("R3 to D", line_state, 4);
        chk("R3 done", cpu_done, 1);
        chk("R3 no upd", bus_req, 0);
        snoop(2'd1, '0, 1, 1, 0, "R6 rd on D");
        chk("R6 D->Sm", line_state, 3);
        evict_owner("R7 wb Sm");
        cpu_issue(2'd1, 32'h22);
        grant(1'b1, 2'd1, "R3 rd shared");
        chk("R3 mid Sc", line_state, 2);
        chk("R3 not done", cpu_done, 0);
        chk("R3 bus_word", bus_word, 32'h22);
        grant(1'b1, 2'd2, "R3 upd");
        chk("R3 to Sm", line_state, 3);
        chk("R3 done 2", cpu_done, 1);
        evict_owner("R7 wb Sm 2");
    endtask

    task automatic t_excl_write();
        cpu_issue(2'd0, '0);
        grant(1'b0, 2'd1, "R4 fill");
        cpu_issue(2'd1, 32'h5);
        chk("R4 E->D", line_state, 4);
        chk("R4 E silent", bus_req, 0);
        chk("R4 E done", cpu_done, 1);
        evict_owner("R7 wb after E");
    endtask

    task automatic t_snoop_priority();
        cpu_issue(2'd0, '0);
        grant(1'b0, 2'd1, "R8 fill");
        cpu_valid = 1; cpu_op = 2'd1; cpu_wdata = 32'h9;
        snp_valid = 1; snp_cmd = 2'd1; snp_word = '0;
        #1;
        chk("R8 ready low", cpu_ready, 0);
        @(negedge clk);
        cpu_valid = 0; snp_valid = 0;
        chk("R8 snoop won", line_state, 2);
        chk("R8 no done", cpu_done, 0);
        chk("R8 no bus", bus_req, 0);
        evict_clean("R8 cleanup");
    endtask

    task automatic t_nop();
        cpu_issue(2'd0, '0);
        grant(1'b0, 2'd1, "R9 fill");
        cpu_issue(2'd3, 32'hF);
        chk("R9 state", line_state, 1);
        chk("R9 done", cpu_done, 0);
        chk("R9 bus", bus_req, 0);
        evict_clean("R9 cleanup");
    endtask

    task automatic t_absent_snoop();
        snoop(2'd1, '0, 0, 0, 0, "R10 rd");
        snoop(2'd2, 32'h3, 0, 0, 0, "R10 upd");
        chk("R10 state", line_state, 0);
    endtask

    task automatic t_late_evict();
        cpu_issue(2'd0, '0);
        grant(1'b1, 2'd1, "R11 fill");
        cpu_issue(2'd1, 32'h7);
        grant(1'b1, 2'd2, "R11 own");
        chk("R11 Sm", line_state, 3);
        cpu_issue(2'd2, '0);
        chk("R11 wb pending", bus_cmd, 3);
        snoop(2'd2, 32'h8, 1, 0, 1, "R11 demote");
        chk("R11 now Sc", line_state, 2);
        grant(1'b0, 2'd0, "R11 empty slot");
        chk("R11 none", line_state, 0);
        chk("R11 done", cpu_done, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst = 1; cpu_valid = 0; cpu_op = 0; cpu_wdata = '0;
        bus_gnt = 0; bus_shared = 0; snp_valid = 0; snp_cmd = 0; snp_word = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        @(negedge clk);
        t_read_miss();
        t_write_hit_update();
        t_write_miss();
        t_excl_write();
        t_snoop_priority();
        t_nop();
        t_absent_snoop();
        t_late_evict();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule